// File: doc/BRIEF.md
# Floating-Point Context Status Gate

This block keeps the two-bit floating-point context status field of the machine status register, together with the read-only summary bit that reports a Dirty context. The context it tracks is the whole floating-point state: the floating-point control and status CSRs and the thirty-two floating-point data registers. Software changes the field through CSR instructions aimed at the machine status register. Hardware raises the field to Dirty whenever floating-point state changes.

In the same cycle the block tells the instruction decoder whether the floating-point context is switched off. When it is off, the block raises an illegal-instruction flag for any access to floating-point state. Such an access is either a pre-decoded floating-point instruction or a CSR request to one of the three floating-point CSRs. A build-time parameter removes the floating-point unit. In that build the field is tied to zero and every floating-point access is illegal.

Top module: `fpctx_gate`

## Requirements
- R1: After reset the status field is Off (00), the readback word is all zeros and `fs_off_o` is 1.
- R2: The readback word holds the field in bits 14:13 (Off=00, Initial=01, Clean=10, Dirty=11) and the summary bit in bit 31. Bit 31 is 1 exactly when the field is Dirty. Every other bit reads 0.
- R3: A CSR request to address 0x300 changes the field at the next clock edge, as set by the operation code. Code 00 writes bits 14:13 of the write data. Code 01 ORs them into the field. Code 10 clears the field bits where they are 1. Codes 01 and 10 with `csr_src_zero_i` high, and code 11, leave the field unchanged.
- R4: With the unit present, a pulse on `fp_state_wr_i` sets the field to Dirty at the next edge, whatever its current value.
- R5: With the unit present and the field not Off, a writing CSR request to 0x001, 0x002 or 0x003 sets the field to Dirty at the next edge. A non-writing request to the same addresses leaves the field unchanged.
- R6: A writing request to 0x300 and a Dirty event in the same cycle: the CSR write decides the next value.
- R7: With the field Off, `illegal_o` is 1 in the same cycle as `fp_insn_i`, or as a CSR request to 0x001–0x003, whatever the operation. This includes a set on 0x002 with a nonzero source. Such a rejected CSR access does not change the field.
- R8: `illegal_o` is 0 whenever the field is not Off. It is also 0 for CSR requests to any address other than 0x001–0x003.
- R9: `fs_off_o` is 1 exactly when the field is Off.
- R10: With the unit absent, the field always reads 00. CSR writes and `fp_state_wr_i` have no effect, and every floating-point access raises `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_req_i | input | 1 | CSR instruction present this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 00 write, 01 set, 10 clear, 11 none |
| csr_src_zero_i | input | 1 | Source operand field is zero (set/clear do not write) |
| csr_wdata_i | input | 32 | CSR write operand |
| fp_insn_i | input | 1 | Pre-decoded instruction that touches floating-point registers |
| fp_state_wr_i | input | 1 | Floating-point register or flag update strobe |
| mstatus_rdata_o | output | 32 | Status register readback (field and summary bit only) |
| fs_off_o | output | 1 | Floating-point context is Off |
| illegal_o | output | 1 | Illegal-instruction flag for a floating-point access |

## Verification
The bound checker checks four things on every cycle:
- the summary bit tracks a Dirty field;
- the off flag matches the field;
- the illegal flag follows an access while the field is Off, and stays low otherwise;
- the field holds when nothing writes it, goes to Dirty after an unopposed update, and stays zero in the build without the unit.

Only the bench scenarios can show the exact results of write, set and clear, and that a set or clear with a zero source has no effect. The same holds for the CSR write winning over a same-cycle Dirty event, and for reads of the floating-point CSRs leaving the field alone. A behavioural model checks both builds side by side with identical stimulus.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

  typedef enum logic [1:0] {
    FS_OFF   = 2'b00,
    FS_INIT  = 2'b01,
    FS_CLEAN = 2'b10,
    FS_DIRTY = 2'b11
  } fs_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } csr_op_e;

  localparam int unsigned CSR_AW = 12;
  localparam logic [CSR_AW-1:0] ADDR_MSTATUS = 12'h300;
  localparam logic [CSR_AW-1:0] ADDR_FFLAGS  = 12'h001;
  localparam logic [CSR_AW-1:0] ADDR_FRM     = 12'h002;
  localparam logic [CSR_AW-1:0] ADDR_FCSR    = 12'h003;

  // Whether an operation writes, given a zero source operand field
  function automatic logic op_writes(csr_op_e op, logic src_zero);
    case (op)
      OP_WRITE: op_writes = 1'b1;
      OP_SET,
      OP_CLEAR: op_writes = !src_zero;
      default:  op_writes = 1'b0;
    endcase
  endfunction

  // New field value after a CSR operation
  function automatic logic [1:0] fs_apply(csr_op_e op, logic [1:0] cur, logic [1:0] bits);
    case (op)
      OP_WRITE: fs_apply = bits;
      OP_SET:   fs_apply = cur | bits;
      OP_CLEAR: fs_apply = cur & ~bits;
      default:  fs_apply = cur;
    endcase
  endfunction

  function automatic logic is_fp_csr(logic [CSR_AW-1:0] addr);
    is_fp_csr = (addr == ADDR_FFLAGS) || (addr == ADDR_FRM) || (addr == ADDR_FCSR);
  endfunction

endpackage

// File: rtl/fpctx_csr_decode.sv
module fpctx_csr_decode
  import fpctx_pkg::*;
(
  input  logic              req_i,
  input  logic [CSR_AW-1:0] addr_i,
  input  logic [1:0]        op_i,
  input  logic              src_zero_i,
  output logic              hit_status_o,
  output logic              hit_fpcsr_o,
  output logic              writes_o
);
  csr_op_e op;
  assign op = csr_op_e'(op_i);

  always_comb begin
    hit_status_o = req_i && (addr_i == ADDR_MSTATUS);
    hit_fpcsr_o  = req_i && is_fp_csr(addr_i);
    writes_o     = req_i && op_writes(op, src_zero_i);
  end
endmodule

// File: rtl/fpctx_fs_reg.sv
module fpctx_fs_reg
  import fpctx_pkg::*;
#(
  parameter bit FPU_PRESENT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       status_wr_i,
  input  logic [1:0] op_i,
  input  logic [1:0] wbits_i,
  input  logic       dirty_evt_i,
  output logic [1:0] fs_q
);
  generate
    if (FPU_PRESENT) begin : g_fpu
      logic [1:0] fs_d;
      always_comb begin
        fs_d = fs_q;
        if (status_wr_i)      fs_d = fs_apply(csr_op_e'(op_i), fs_q, wbits_i);
        else if (dirty_evt_i) fs_d = FS_DIRTY;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fs_q <= FS_OFF;
        else         fs_q <= fs_d;
      end
    end else begin : g_nofpu
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, status_wr_i, op_i, wbits_i, dirty_evt_i};
      assign fs_q = FS_OFF;
    end
  endgenerate
endmodule

// File: rtl/fpctx_legality.sv
module fpctx_legality
  import fpctx_pkg::*;
(
  input  logic [1:0] fs_i,
  input  logic       fp_insn_i,
  input  logic       hit_fpcsr_i,
  output logic       fp_access_o,
  output logic       fs_off_o,
  output logic       illegal_o
);
  always_comb begin
    fs_off_o    = (fs_i == FS_OFF);
    fp_access_o = fp_insn_i || hit_fpcsr_i;
    illegal_o   = fp_access_o && fs_off_o;
  end
endmodule

// File: rtl/fpctx_gate.sv
module fpctx_gate
  import fpctx_pkg::*;
#(
  parameter bit          FPU_PRESENT = 1'b1,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned FS_LSB      = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_req_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic              csr_src_zero_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              fp_insn_i,
  input  logic              fp_state_wr_i,
  output logic [XLEN-1:0]   mstatus_rdata_o,
  output logic              fs_off_o,
  output logic              illegal_o
);
  localparam int unsigned FS_MSB = FS_LSB + 1;
  localparam int unsigned SD_BIT = XLEN - 1;

  logic       hit_status, hit_fpcsr, writes;
  logic       mstatus_wr, dirty_evt, fp_access;
  logic [1:0] fs_q, wbits;

  assign wbits = csr_wdata_i[FS_MSB:FS_LSB];

  logic unused_wdata;
  assign unused_wdata = ^{csr_wdata_i[XLEN-1:FS_MSB+1], csr_wdata_i[FS_LSB-1:0]};

  fpctx_csr_decode u_dec (
    .req_i        (csr_req_i),
    .addr_i       (csr_addr_i),
    .op_i         (csr_op_i),
    .src_zero_i   (csr_src_zero_i),
    .hit_status_o (hit_status),
    .hit_fpcsr_o  (hit_fpcsr),
    .writes_o     (writes)
  );

  fpctx_legality u_leg (
    .fs_i        (fs_q),
    .fp_insn_i   (fp_insn_i),
    .hit_fpcsr_i (hit_fpcsr),
    .fp_access_o (fp_access),
    .fs_off_o    (fs_off_o),
    .illegal_o   (illegal_o)
  );

  // Named events for the checker
  assign mstatus_wr = hit_status && writes;
  assign dirty_evt  = fp_state_wr_i || (hit_fpcsr && writes && !fs_off_o);

  fpctx_fs_reg #(.FPU_PRESENT(FPU_PRESENT)) u_fs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .status_wr_i (mstatus_wr),
    .op_i        (csr_op_i),
    .wbits_i     (wbits),
    .dirty_evt_i (dirty_evt),
    .fs_q        (fs_q)
  );

  always_comb begin
    mstatus_rdata_o                = '0;
    mstatus_rdata_o[FS_MSB:FS_LSB] = fs_q;
    mstatus_rdata_o[SD_BIT]        = (fs_q == FS_DIRTY);
  end
endmodule

// File: rtl/fpctx_gate_chk.sv
module fpctx_gate_chk #(
  parameter bit FPU_PRESENT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] fs_q,
  input logic       mstatus_wr,
  input logic       dirty_evt,
  input logic       fp_access,
  input logic       illegal_o,
  input logic       fs_off_o,
  input logic       sd_bit
);
  assert_sd_tracks_dirty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_bit == (fs_q == 2'b11));

  assert_dirty_after_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FPU_PRESENT && dirty_evt && !mstatus_wr) |=> (fs_q == 2'b11));

  assert_field_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mstatus_wr && !dirty_evt) |=> $stable(fs_q));

  assert_illegal_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_access && fs_off_o) |-> illegal_o);

  assert_legal_when_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q != 2'b00) |-> !illegal_o);

  assert_off_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_off_o == (fs_q == 2'b00));

  assert_absent_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FPU_PRESENT |-> (fs_q == 2'b00));
endmodule

bind fpctx_gate fpctx_gate_chk #(.FPU_PRESENT(FPU_PRESENT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fs_q       (fs_q),
  .mstatus_wr (mstatus_wr),
  .dirty_evt  (dirty_evt),
  .fp_access  (fp_access),
  .illegal_o  (illegal_o),
  .fs_off_o   (fs_off_o),
  .sd_bit     (mstatus_rdata_o[31])
);

// File: tb/fpctx_gate_tb_top.sv
module fpctx_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  op = 2'b11;
  logic        src_zero = 1'b0;
  logic [31:0] wdata = '0;
  logic        fpi = 1'b0;
  logic        fpw = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic        off_a, off_b, ill_a, ill_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int fs_a = 0;  // model: unit present
  int fs_b = 0;  // model: unit absent

  always #4 clk = ~clk;  // 125 MHz

  fpctx_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_addr_i(addr), .csr_op_i(op),
    .csr_src_zero_i(src_zero), .csr_wdata_i(wdata), .fp_insn_i(fpi), .fp_state_wr_i(fpw),
    .mstatus_rdata_o(rd_a), .fs_off_o(off_a), .illegal_o(ill_a));

  fpctx_gate #(.FPU_PRESENT(1'b0)) dut_nofpu_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_addr_i(addr), .csr_op_i(op),
    .csr_src_zero_i(src_zero), .csr_wdata_i(wdata), .fp_insn_i(fpi), .fp_state_wr_i(fpw),
    .mstatus_rdata_o(rd_b), .fs_off_o(off_b), .illegal_o(ill_b));

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_fpcsr(logic [11:0] a);
    return a >= 12'h001 && a <= 12'h003;
  endfunction

  function automatic logic [31:0] word_of(int fs);
    logic [31:0] w = 32'd0;
    w[14:13] = fs[1:0];
    w[31] = (fs == 3);
    return w;
  endfunction

  function automatic int next_fs(int fs);
    bit wr = (op == 2'b00) || ((op == 2'b01 || op == 2'b10) && !src_zero);
    int b = int'(wdata[14:13]);
    if (req && addr == 12'h300 && wr) begin
      if (op == 2'b00) return b;
      if (op == 2'b01) return fs | b;
      return fs & ~b & 3;
    end
    if (fpw || (req && is_fpcsr(addr) && wr && fs != 0)) return 3;
    return fs;
  endfunction

  // Drive one cycle, compare combinational outputs, advance the models
  task automatic step(string tag, bit r, logic [11:0] a, logic [1:0] o, bit sz,
                      logic [31:0] wd, bit fi, bit fw);
    bit acc;
    req = r; addr = a; op = o; src_zero = sz; wdata = wd; fpi = fi; fpw = fw;
    #1;
    acc = fi || (r && is_fpcsr(a));
    check({tag, "/R2"}, "rdata", rd_a, word_of(fs_a));
    check({tag, "/R9"}, "fs_off", off_a, fs_a == 0);
    check({tag, (fs_a == 0) ? "/R7" : "/R8"}, "illegal", ill_a, acc && fs_a == 0);
    check({tag, "/R10"}, "nofpu rdata", rd_b, 0);
    check({tag, "/R10"}, "nofpu illegal", ill_b, acc);
    @(posedge clk);
    fs_a = next_fs(fs_a);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 12'h000, 2'b11, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rdata in reset", rd_a, 0);
    check("R1", "fs_off in reset", off_a, 1);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1");
    // Off: floating-point instruction and set on frm are illegal, no change
    step("R7", 0, 12'h000, 2'b11, 0, 0, 1, 0);
    step("R7", 1, 12'h002, 2'b01, 0, 32'h7, 0, 0);
    step("R7", 1, 12'h003, 2'b00, 0, 32'hff, 0, 0);
    idle("R7");
    // Software sets Initial
    step("R3", 1, 12'h300, 2'b00, 0, 32'h0000_2000, 0, 0);
    idle("R3");
    // Read of fcsr: legal, no dirty
    step("R5", 1, 12'h003, 2'b01, 1, 0, 0, 0);
    idle("R5");
    // Write frm: Dirty
    step("R5", 1, 12'h002, 2'b00, 0, 32'h1, 0, 0);
    idle("R5");
    // Clear bit 14: Dirty -> Initial
    step("R3", 1, 12'h300, 2'b10, 0, 32'h0000_4000, 0, 0);
    idle("R3");
    // Set with zero source: no effect
    step("R3", 1, 12'h300, 2'b01, 1, 32'h0000_6000, 0, 0);
    step("R3", 1, 12'h300, 2'b11, 0, 32'h0000_6000, 0, 0);
    idle("R3");
    // Hardware update strobe
    step("R4", 0, 12'h000, 2'b11, 0, 0, 0, 1);
    idle("R4");
    // CSR write to Clean concurrent with strobe: CSR wins
    step("R6", 1, 12'h300, 2'b00, 0, 32'h0000_4000, 0, 1);
    idle("R6");
    // Other address, legal instruction while on
    step("R8", 1, 12'h305, 2'b00, 0, 32'hffff_ffff, 0, 0);
    step("R8", 0, 12'h000, 2'b11, 0, 0, 1, 0);
    // Set Initial bit: Clean|Initial -> Dirty
    step("R3", 1, 12'h300, 2'b01, 0, 32'h0000_2000, 0, 0);
    idle("R2");
    // Back to Off, strobe still forces Dirty
    step("R3", 1, 12'h300, 2'b00, 0, 32'hffff_9fff, 0, 0);
    idle("R9");
    step("R4", 0, 12'h000, 2'b11, 0, 0, 0, 1);
    idle("R4");
    step("R3", 1, 12'h300, 2'b00, 0, 0, 0, 0);
    // Off again: fflags write rejected and does not dirty
    step("R7", 1, 12'h001, 2'b00, 0, 32'h1f, 0, 0);
    idle("R7");
    idle("R10");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule